// File: doc/BRIEF.md
# NOR Flash Command-Entry Decoder with Unlock Bypass

This block models the command-entry front end of a parallel NOR flash bank. It watches host bus write cycles (an address and a 16-bit data word) and recognises the unlock-prefixed program and erase sequences. When a sequence is complete it reports the decoded command as a one-clock pulse, together with the address and data of the final write. A sequence that goes wrong partway through raises a one-clock abort pulse, and the decoder goes back to read mode.

A shortcut mode, called unlock bypass, skips the two-write unlock prefix. Software enters it with a command sequence. An external accelerate level also forces the block into this mode, and dropping that level forces it back out. In bypass mode the block accepts only four commands: program, sector erase, chip erase and the two-write exit. Any other write is dropped and the block stays in bypass mode. A busy input freezes decoding while an embedded operation runs elsewhere.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset the block is in read mode: `bypass_mode`, `cmd_valid` and `abort` are all low.
- R2: In read mode the writes AAh@555h, 55h@2AAh and A0h@any address, followed by a fourth write to any address, produce `cmd_valid` for one clock. This pulse is visible in the cycle after the fourth write. It carries `cmd_kind`=0 (program) and the fourth write's address and data.
- R3: The writes AAh@555h, 55h@2AAh, 80h, AAh@555h and 55h@2AAh, then a sixth write, give one of two results. A sixth write of 10h@555h pulses `cmd_kind`=2 (chip erase). A sixth write of 30h@any address pulses `cmd_kind`=1 (sector erase) with that address.
- R4: A wrong address or data value at any step after the first unlock write pulses `abort` for one clock and returns the block to read mode. In read mode, a write that is not AAh@555h is ignored and does not abort.
- R5: The writes AAh@555h, 55h@2AAh and 20h enter bypass mode, and `bypass_mode` goes high.
- R6: In bypass mode, A0h followed by any write produces a program pulse with that write's address and data. The block stays in bypass mode.
- R7: In bypass mode, 80h followed by 10h@555h produces a chip erase pulse. 80h followed by 30h@any address produces a sector erase pulse with that address.
- R8: In bypass mode, any write other than A0h, 80h or 90h at the start of a command is ignored and the block stays in bypass mode. An invalid write after 80h returns to the bypass idle state without an abort.
- R9: In bypass mode, 90h@any address followed by 00h@any address returns the block to read mode. A second write other than 00h leaves the block in bypass mode.
- R10: While `accel` is high, the block is in bypass mode from the next clock on. A partial normal sequence is dropped without an abort, and the exit sequence does not leave bypass mode.
- R11: A falling edge of `accel` returns the block to read mode on the next clock, from any state.
- R12: While `busy` is high, writes are ignored and the decoder keeps its sequence state. No command or abort pulse is produced.
- R13: Only the low 11 address bits (`MATCH_W`) and the low data byte take part in matching. Higher address bits and the upper data byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| busy | input | 1 | Stall: writes are ignored while high |
| accel | input | 1 | Accelerate level, forces bypass mode |
| cmd_valid | output | 1 | One-clock decoded command pulse |
| cmd_kind | output | 2 | 0 program, 1 sector erase, 2 chip erase |
| cmd_addr | output | ADDR_W | Address of the final write of the command |
| cmd_data | output | DATA_W | Data of the final write of the command |
| bypass_mode | output | 1 | High while in unlock bypass mode |
| abort | output | 1 | One-clock pulse on an invalid normal sequence |

## Verification
The bench uses the default parameters: ADDR_W=22, MATCH_W=11 and DATA_W=16. With these values the address has eleven bits above the matched field, so the bench can set high address bits and a non-zero upper data byte on the unlock writes and show that matching still succeeds. Each scenario starts from a known mode. Ignored writes are then proven harmless by completing a legal command afterwards and checking the pulse.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PROG,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3,
        ST_BP_IDLE,
        ST_BP_PROG,
        ST_BP_ERS,
        ST_BP_EXIT
    } dec_state_e;

    typedef enum logic [1:0] {
        CMD_PROGRAM = 2'd0,
        CMD_SECTOR  = 2'd1,
        CMD_CHIP    = 2'd2
    } cmd_kind_e;

    localparam int NCODE = 9;
    localparam int CI_AA = 0;
    localparam int CI_55 = 1;
    localparam int CI_A0 = 2;
    localparam int CI_80 = 3;
    localparam int CI_90 = 4;
    localparam int CI_20 = 5;
    localparam int CI_10 = 6;
    localparam int CI_30 = 7;
    localparam int CI_00 = 8;

    localparam logic [7:0] CODE_TAB [NCODE] = '{
        8'hAA, 8'h55, 8'hA0, 8'h80, 8'h90, 8'h20, 8'h10, 8'h30, 8'h00
    };

    function automatic logic is_bypass(input dec_state_e s);
        return (s == ST_BP_IDLE) || (s == ST_BP_PROG) ||
               (s == ST_BP_ERS)  || (s == ST_BP_EXIT);
    endfunction

endpackage

// File: rtl/nor_wr_classify.sv
module nor_wr_classify
    import nor_cmd_pkg::*;
#(
    parameter int CMP_W = 11,
    parameter logic [CMP_W-1:0] UNL_A1 = 11'h555,
    parameter logic [CMP_W-1:0] UNL_A2 = 11'h2AA
) (
    input  logic [CMP_W-1:0] addr_lo,
    input  logic [7:0]       data_lo,
    output logic             at_unl1,
    output logic             at_unl2,
    output logic [NCODE-1:0] code_hit
);

    assign at_unl1 = (addr_lo == UNL_A1);
    assign at_unl2 = (addr_lo == UNL_A2);

    for (genvar i = 0; i < NCODE; i++) begin : g_code
        assign code_hit[i] = (data_lo == CODE_TAB[i]);
    end

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              accel,
    input  logic              at_unl1,
    input  logic              at_unl2,
    input  logic [NCODE-1:0]  code_hit,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              bypass_mode,
    output logic              abort
);

    typedef struct packed {
        dec_state_e        st;
        logic              accel_prev;
        logic              vld;
        cmd_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              abort;
    } fsm_reg_t;

    fsm_reg_t q, d;

    logic take_wr;
    assign take_wr = wr_en && !busy;

    always_comb begin
        d            = q;
        d.vld        = 1'b0;
        d.abort      = 1'b0;
        d.accel_prev = accel;

        if (q.accel_prev && !accel) begin
            d.st = ST_READ;
        end else if (accel && !is_bypass(q.st)) begin
            d.st = ST_BP_IDLE;
        end else if (take_wr) begin
            case (q.st)
                ST_READ: begin
                    if (at_unl1 && code_hit[CI_AA]) d.st = ST_UNL1;
                end
                ST_UNL1: begin
                    if (at_unl2 && code_hit[CI_55]) begin
                        d.st = ST_UNL2;
                    end else begin
                        d.st    = ST_READ;
                        d.abort = 1'b1;
                    end
                end
                ST_UNL2: begin
                    if (code_hit[CI_A0])      d.st = ST_PROG;
                    else if (code_hit[CI_80]) d.st = ST_ERS1;
                    else if (code_hit[CI_20]) d.st = ST_BP_IDLE;
                    else begin
                        d.st    = ST_READ;
                        d.abort = 1'b1;
                    end
                end
                ST_PROG: begin
                    d.st   = ST_READ;
                    d.vld  = 1'b1;
                    d.kind = CMD_PROGRAM;
                    d.addr = wr_addr;
                    d.data = wr_data;
                end
                ST_ERS1: begin
                    if (at_unl1 && code_hit[CI_AA]) begin
                        d.st = ST_ERS2;
                    end else begin
                        d.st    = ST_READ;
                        d.abort = 1'b1;
                    end
                end
                ST_ERS2: begin
                    if (at_unl2 && code_hit[CI_55]) begin
                        d.st = ST_ERS3;
                    end else begin
                        d.st    = ST_READ;
                        d.abort = 1'b1;
                    end
                end
                ST_ERS3: begin
                    d.st = ST_READ;
                    if (at_unl1 && code_hit[CI_10]) begin
                        d.vld  = 1'b1;
                        d.kind = CMD_CHIP;
                        d.addr = wr_addr;
                        d.data = wr_data;
                    end else if (code_hit[CI_30]) begin
                        d.vld  = 1'b1;
                        d.kind = CMD_SECTOR;
                        d.addr = wr_addr;
                        d.data = wr_data;
                    end else begin
                        d.abort = 1'b1;
                    end
                end
                ST_BP_IDLE: begin
                    if (code_hit[CI_A0])      d.st = ST_BP_PROG;
                    else if (code_hit[CI_80]) d.st = ST_BP_ERS;
                    else if (code_hit[CI_90]) d.st = ST_BP_EXIT;
                end
                ST_BP_PROG: begin
                    d.st   = ST_BP_IDLE;
                    d.vld  = 1'b1;
                    d.kind = CMD_PROGRAM;
                    d.addr = wr_addr;
                    d.data = wr_data;
                end
                ST_BP_ERS: begin
                    d.st = ST_BP_IDLE;
                    if (at_unl1 && code_hit[CI_10]) begin
                        d.vld  = 1'b1;
                        d.kind = CMD_CHIP;
                        d.addr = wr_addr;
                        d.data = wr_data;
                    end else if (code_hit[CI_30]) begin
                        d.vld  = 1'b1;
                        d.kind = CMD_SECTOR;
                        d.addr = wr_addr;
                        d.data = wr_data;
                    end
                end
                ST_BP_EXIT: begin
                    if (code_hit[CI_00] && !accel) d.st = ST_READ;
                    else                           d.st = ST_BP_IDLE;
                end
                default: d.st = ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st         <= ST_READ;
            q.accel_prev <= 1'b0;
            q.vld        <= 1'b0;
            q.kind       <= CMD_PROGRAM;
            q.addr       <= '0;
            q.data       <= '0;
            q.abort      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cmd_valid   = q.vld;
    assign cmd_kind    = q.kind;
    assign cmd_addr    = q.addr;
    assign cmd_data    = q.data;
    assign abort       = q.abort;
    assign bypass_mode = is_bypass(q.st);

    // Accelerate level holds the block in bypass mode (R10)
    assert_accel_forces_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accel |=> bypass_mode);

    // Falling accelerate level leaves bypass mode (R11)
    assert_accel_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.accel_prev && !accel) |=> !bypass_mode);

    // Busy suppresses all pulses (R12)
    assert_busy_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!cmd_valid && !abort));

    // Aborts come only from normal-mode sequences (R4)
    assert_abort_normal_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> !$past(bypass_mode));

    // A command pulse follows an accepted write (R2)
    assert_cmd_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(wr_en && !busy));

    // Command pulses last a single clock (R6)
    assert_cmd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // Only the three defined command kinds appear (R3)
    assert_kind_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_kind != 2'd3));

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16,
    parameter int MATCH_W = 11,
    parameter logic [31:0] UNL_ADDR1 = 32'h555,
    parameter logic [31:0] UNL_ADDR2 = 32'h2AA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              accel,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              bypass_mode,
    output logic              abort
);

    localparam int CMP_W = (MATCH_W < ADDR_W) ? MATCH_W : ADDR_W;
    localparam logic [CMP_W-1:0] A1 = UNL_ADDR1[CMP_W-1:0];
    localparam logic [CMP_W-1:0] A2 = UNL_ADDR2[CMP_W-1:0];

    logic             at_unl1;
    logic             at_unl2;
    logic [NCODE-1:0] code_hit;

    nor_wr_classify #(
        .CMP_W  (CMP_W),
        .UNL_A1 (A1),
        .UNL_A2 (A2)
    ) u_classify (
        .addr_lo  (wr_addr[CMP_W-1:0]),
        .data_lo  (wr_data[7:0]),
        .at_unl1  (at_unl1),
        .at_unl2  (at_unl2),
        .code_hit (code_hit)
    );

    nor_cmd_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .busy        (busy),
        .accel       (accel),
        .at_unl1     (at_unl1),
        .at_unl2     (at_unl2),
        .code_hit    (code_hit),
        .cmd_valid   (cmd_valid),
        .cmd_kind    (cmd_kind),
        .cmd_addr    (cmd_addr),
        .cmd_data    (cmd_data),
        .bypass_mode (bypass_mode),
        .abort       (abort)
    );

endmodule

// File: tb/nor_cmd_decoder_bench.sv
module nor_cmd_decoder_bench;

    localparam int ADDR_W = 22;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              busy = 1'b0;
    logic              accel = 1'b0;
    logic              cmd_valid;
    logic [1:0]        cmd_kind;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              bypass_mode;
    logic              abort;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    nor_cmd_decoder u_nor_cmd_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .busy        (busy),
        .accel       (accel),
        .cmd_valid   (cmd_valid),
        .cmd_kind    (cmd_kind),
        .cmd_addr    (cmd_addr),
        .cmd_data    (cmd_data),
        .bypass_mode (bypass_mode),
        .abort       (abort)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] dt);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = dt;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic expect_cmd(input string req, input logic [1:0] k,
                              input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] dt);
        chk(cmd_valid == 1'b1, req, "cmd_valid", 32'(cmd_valid), 32'd1);
        chk(cmd_kind == k, req, "cmd_kind", 32'(cmd_kind), 32'(k));
        chk(cmd_addr == a, req, "cmd_addr", 32'(cmd_addr), 32'(a));
        chk(cmd_data == dt, req, "cmd_data", 32'(cmd_data), 32'(dt));
    endtask

    task automatic expect_quiet(input string req);
        chk(cmd_valid == 1'b0, req, "cmd_valid", 32'(cmd_valid), 32'd0);
        chk(abort == 1'b0, req, "abort", 32'(abort), 32'd0);
    endtask

    task automatic expect_mode(input string req, input logic m);
        chk(bypass_mode == m, req, "bypass_mode", 32'(bypass_mode), 32'(m));
    endtask

    task automatic unlock();
        wr(22'h000555, 16'h00AA);
        wr(22'h0002AA, 16'h0055);
    endtask

    task automatic t_reset();
        expect_mode("R1", 1'b0);
        expect_quiet("R1");
    endtask

    task automatic t_normal_program();
        unlock();
        wr(22'h000123, 16'h00A0);
        expect_quiet("R2");
        wr(22'h031234, 16'hBEEF);
        expect_cmd("R2", 2'd0, 22'h031234, 16'hBEEF);
        idle();
        chk(cmd_valid == 1'b0, "R2", "pulse width", 32'(cmd_valid), 32'd0);
    endtask

    task automatic t_normal_erase();
        unlock();
        wr(22'h000555, 16'h0080);
        unlock();
        wr(22'h000555, 16'h0010);
        expect_cmd("R3", 2'd2, 22'h000555, 16'h0010);
        unlock();
        wr(22'h000555, 16'h0080);
        unlock();
        wr(22'h012000, 16'h0030);
        expect_cmd("R3", 2'd1, 22'h012000, 16'h0030);
    endtask

    task automatic t_abort();
        wr(22'h000100, 16'h00A0);
        expect_quiet("R4");
        wr(22'h000555, 16'h00AA);
        wr(22'h0002AB, 16'h0055);
        chk(abort == 1'b1, "R4", "abort on bad addr", 32'(abort), 32'd1);
        expect_mode("R4", 1'b0);
        idle();
        chk(abort == 1'b0, "R4", "abort width", 32'(abort), 32'd0);
        unlock();
        wr(22'h000555, 16'h0080);
        unlock();
        wr(22'h000555, 16'h0050);
        chk(abort == 1'b1, "R4", "abort on bad erase code", 32'(abort), 32'd1);
        chk(cmd_valid == 1'b0, "R4", "no cmd on abort", 32'(cmd_valid), 32'd0);
        wr(22'h000777, 16'h0000);
        expect_quiet("R4");
    endtask

    task automatic t_alias();
        wr(22'h3FF555, 16'hFFAA);
        wr(22'h2002AA, 16'h1255);
        wr(22'h000000, 16'h34A0);
        expect_quiet("R13");
        wr(22'h00ABCD, 16'h5A5A);
        expect_cmd("R13", 2'd0, 22'h00ABCD, 16'h5A5A);
    endtask

    task automatic t_enter_bypass();
        unlock();
        wr(22'h000555, 16'h0020);
        expect_mode("R5", 1'b1);
        expect_quiet("R5");
    endtask

    task automatic t_bypass_program();
        wr(22'h000000, 16'h00A0);
        expect_quiet("R6");
        wr(22'h004567, 16'h1357);
        expect_cmd("R6", 2'd0, 22'h004567, 16'h1357);
        expect_mode("R6", 1'b1);
    endtask

    task automatic t_bypass_erase();
        wr(22'h000000, 16'h0080);
        wr(22'h000555, 16'h0010);
        expect_cmd("R7", 2'd2, 22'h000555, 16'h0010);
        wr(22'h000000, 16'h0080);
        wr(22'h008000, 16'h0030);
        expect_cmd("R7", 2'd1, 22'h008000, 16'h0030);
        expect_mode("R7", 1'b1);
    endtask

    task automatic t_bypass_ignore();
        wr(22'h000555, 16'h00AA);
        expect_quiet("R8");
        expect_mode("R8", 1'b1);
        wr(22'h0002AA, 16'h0055);
        wr(22'h000555, 16'h0020);
        expect_quiet("R8");
        wr(22'h000000, 16'h00A0);
        wr(22'h000042, 16'h0042);
        expect_cmd("R8", 2'd0, 22'h000042, 16'h0042);
        wr(22'h000000, 16'h0080);
        wr(22'h000555, 16'h0077);
        expect_quiet("R8");
        expect_mode("R8", 1'b1);
        wr(22'h000000, 16'h00A0);
        wr(22'h000043, 16'h0043);
        expect_cmd("R8", 2'd0, 22'h000043, 16'h0043);
    endtask

    task automatic t_exit();
        wr(22'h000000, 16'h0090);
        wr(22'h000000, 16'h1234);
        expect_mode("R9", 1'b1);
        wr(22'h000000, 16'h0090);
        wr(22'h0001F0, 16'h0000);
        expect_mode("R9", 1'b0);
        expect_quiet("R9");
        wr(22'h000000, 16'h00A0);
        wr(22'h000044, 16'h0044);
        chk(cmd_valid == 1'b0, "R9", "bypass program after exit", 32'(cmd_valid), 32'd0);
    endtask

    task automatic t_accel();
        wr(22'h000555, 16'h00AA);
        accel = 1'b1;
        idle();
        expect_mode("R10", 1'b1);
        chk(abort == 1'b0, "R10", "no abort on forced entry", 32'(abort), 32'd0);
        wr(22'h000000, 16'h00A0);
        wr(22'h000055, 16'h0066);
        expect_cmd("R10", 2'd0, 22'h000055, 16'h0066);
        wr(22'h000000, 16'h0090);
        wr(22'h000000, 16'h0000);
        expect_mode("R10", 1'b1);
        accel = 1'b0;
        idle();
        expect_mode("R11", 1'b0);
        accel = 1'b1;
        idle();
        wr(22'h000000, 16'h00A0);
        accel = 1'b0;
        idle();
        expect_mode("R11", 1'b0);
        wr(22'h000066, 16'h0077);
        chk(cmd_valid == 1'b0, "R11", "partial bypass program dropped", 32'(cmd_valid), 32'd0);
    endtask

    task automatic t_busy();
        unlock();
        wr(22'h000000, 16'h00A0);
        busy = 1'b1;
        wr(22'h000099, 16'h1111);
        expect_quiet("R12");
        wr(22'h000555, 16'h00AA);
        expect_quiet("R12");
        busy = 1'b0;
        wr(22'h000098, 16'h2222);
        expect_cmd("R12", 2'd0, 22'h000098, 16'h2222);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        t_reset();
        t_normal_program();
        t_normal_erase();
        t_abort();
        t_alias();
        t_enter_bypass();
        t_bypass_program();
        t_bypass_erase();
        t_bypass_ignore();
        t_exit();
        t_accel();
        t_busy();
        repeat (2) idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule